// File: doc/BRIEF.md
# Two-Floor Lift Controller

This block is a clocked Moore-style state machine that runs a lift serving two floors. Two call buttons ask the car to go up or down. Two position sensors tell it when the car has reached the upper or the lower landing. The controller drives four lines: a lamp for the lower landing, a lamp for the upper landing, a drive-up command and a drive-down command. Each drive command runs the motor in that direction and also lights the matching direction arrow.

The state is two bits wide and sits in a single register with a synchronous, active-high reset. One combinational block computes the next state. A decoder turns the state into one active line per state, and a second combinational block forms the outputs from those lines only. Because of this, the outputs change only at a clock edge. Travel ends only when the sensor for the destination floor is seen. Button presses during travel are ignored.

Top module: `lift2_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller enters the lower-landing state. In that state `lamp_lo`=1 and `lamp_hi`, `drive_up` and `drive_dn` are all 0. The state encoding is: lower landing 00, rising 01, upper landing 10, falling 11.
- R2: In the lower-landing state, `req_up`=1 at a clock edge moves the controller to the rising state. After that edge, `drive_up`=1 and the other three outputs are 0.
- R3: In the lower-landing state with `req_up`=0, the controller stays where it is. This holds whatever `req_dn`, `top_sense` and `bot_sense` do.
- R4: In the rising state, `drive_up` stays at 1 for as long as `top_sense` is 0. The first edge with `top_sense`=1 moves the controller to the upper-landing state, where `lamp_hi`=1 and the other outputs are 0.
- R5: In the rising state, `req_up`, `req_dn` and `bot_sense` have no effect.
- R6: In the upper-landing state, `req_dn`=1 at a clock edge moves the controller to the falling state, where `drive_dn`=1 and the other outputs are 0.
- R7: In the upper-landing state with `req_dn`=0, the controller stays where it is. This holds whatever `req_up` and the sensors do.
- R8: In the falling state, `drive_dn` stays at 1 for as long as `bot_sense` is 0. The first edge with `bot_sense`=1 returns the controller to the lower-landing state.
- R9: In the falling state, `req_up`, `req_dn` and `top_sense` have no effect.
- R10: The outputs depend only on the registered state. A change on any input between clock edges leaves all four outputs unchanged until the next edge.
- R11: Outside reset, exactly one of the four outputs is 1. So the two drive commands are never 1 together, and a landing lamp is lit only while the car is stopped.
- R12: If both buttons are pressed in the lower-landing state, the up request is accepted and the controller moves to the rising state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_up | input | 1 | Call button asking the car to go up |
| req_dn | input | 1 | Call button asking the car to go down |
| top_sense | input | 1 | Car is at the upper landing |
| bot_sense | input | 1 | Car is at the lower landing |
| lamp_lo | output | 1 | Lower-landing lamp |
| lamp_hi | output | 1 | Upper-landing lamp |
| drive_up | output | 1 | Motor up and up arrow |
| drive_dn | output | 1 | Motor down and down arrow |

## Verification
The bench presses the opposite button while the car is travelling. A controller that obeyed that press would reverse or stop between floors. It also gives the sensor of the wrong floor during travel, which a controller that decoded the sensors loosely would treat as arrival. It changes inputs in the middle of a cycle and checks that the outputs do not move, which catches a Mealy-style output path that lets a button reach the motor directly. It presses both buttons at the lower landing, which catches a wrong priority that leaves the car parked. It also checks for a car that arrives before its sensor has been seen.

// File: rtl/lift2_pkg.sv
package lift2_pkg;

    localparam int NUM_STATES = 4;
    localparam int STATE_W    = $clog2(NUM_STATES);

    typedef enum logic [STATE_W-1:0] {
        ST_LOW  = 2'b00,
        ST_RISE = 2'b01,
        ST_HIGH = 2'b10,
        ST_FALL = 2'b11
    } lift_state_e;

    typedef struct packed {
        logic req_up;
        logic req_dn;
        logic top_sense;
        logic bot_sense;
    } lift_in_t;

    typedef struct packed {
        logic lamp_lo;
        logic lamp_hi;
        logic drive_up;
        logic drive_dn;
    } lift_out_t;

    // Next-state rule for one clock edge
    function automatic lift_state_e step_state(lift_state_e cur, lift_in_t in);
        lift_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_LOW:  if (in.req_up)    nxt = ST_RISE;
            ST_RISE: if (in.top_sense) nxt = ST_HIGH;
            ST_HIGH: if (in.req_dn)    nxt = ST_FALL;
            ST_FALL: if (in.bot_sense) nxt = ST_LOW;
            default: nxt = ST_LOW;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lift2_next.sv
module lift2_next
    import lift2_pkg::*;
(
    input  lift_state_e cur_state,
    input  lift_in_t    in_bus,
    output lift_state_e nxt_state
);
    always_comb begin
        nxt_state = step_state(cur_state, in_bus);
    end
endmodule

// File: rtl/lift2_decode.sv
module lift2_decode
    import lift2_pkg::*;
(
    input  lift_state_e           cur_state,
    output logic [NUM_STATES-1:0] state_line
);
    for (genvar i = 0; i < NUM_STATES; i++) begin : g_line
        assign state_line[i] = (cur_state == lift_state_e'(STATE_W'(i)));
    end
endmodule

// File: rtl/lift2_outputs.sv
module lift2_outputs
    import lift2_pkg::*;
(
    input  logic [NUM_STATES-1:0] state_line,
    output lift_out_t             out_bus
);
    always_comb begin
        out_bus.lamp_lo  = state_line[ST_LOW];
        out_bus.lamp_hi  = state_line[ST_HIGH];
        out_bus.drive_up = state_line[ST_RISE];
        out_bus.drive_dn = state_line[ST_FALL];
    end
endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl
    import lift2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_up,
    input  logic req_dn,
    input  logic top_sense,
    input  logic bot_sense,
    output logic lamp_lo,
    output logic lamp_hi,
    output logic drive_up,
    output logic drive_dn
);
    lift_state_e           state_q;
    lift_state_e           state_d;
    lift_in_t              in_bus;
    lift_out_t             out_bus;
    logic [NUM_STATES-1:0] state_line;

    assign in_bus = '{req_up: req_up, req_dn: req_dn,
                      top_sense: top_sense, bot_sense: bot_sense};

    lift2_next u_next (
        .cur_state (state_q),
        .in_bus    (in_bus),
        .nxt_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOW;
        else     state_q <= state_d;
    end

    lift2_decode u_decode (
        .cur_state  (state_q),
        .state_line (state_line)
    );

    lift2_outputs u_outputs (
        .state_line (state_line),
        .out_bus    (out_bus)
    );

    assign lamp_lo  = out_bus.lamp_lo;
    assign lamp_hi  = out_bus.lamp_hi;
    assign drive_up = out_bus.drive_up;
    assign drive_dn = out_bus.drive_dn;
endmodule

// File: rtl/lift2_ctrl_chk.sv
module lift2_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_up,
    input logic req_dn,
    input logic top_sense,
    input logic bot_sense,
    input logic lamp_lo,
    input logic lamp_hi,
    input logic drive_up,
    input logic drive_dn
);
    // R1
    reset_home_chk: assert property (@(posedge clk)
        rst |=> (lamp_lo && !lamp_hi && !drive_up && !drive_dn));

    // R11
    one_output_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({lamp_lo, lamp_hi, drive_up, drive_dn}) == 1);

    // R2
    start_up_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_lo && req_up) |=> drive_up);

    // R3
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_lo && !req_up) |=> lamp_lo);

    // R4
    rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_up && !top_sense) |=> drive_up);

    // R4
    arrive_high_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_up && top_sense) |=> lamp_hi);

    // R6
    start_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_hi && req_dn) |=> drive_dn);

    // R7
    park_high_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_hi && !req_dn) |=> lamp_hi);

    // R8
    fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_dn && !bot_sense) |=> drive_dn);

    // R8
    arrive_low_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_dn && bot_sense) |=> lamp_lo);
endmodule

bind lift2_ctrl lift2_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_up    (req_up),
    .req_dn    (req_dn),
    .top_sense (top_sense),
    .bot_sense (bot_sense),
    .lamp_lo   (lamp_lo),
    .lamp_hi   (lamp_hi),
    .drive_up  (drive_up),
    .drive_dn  (drive_dn)
);

// File: tb/lift2_ctrl_test.sv
`timescale 1ns/100ps
module lift2_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_up = 1'b0, req_dn = 1'b0, top_sense = 1'b0, bot_sense = 1'b0;
    logic lamp_lo, lamp_hi, drive_up, drive_dn;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Output pattern {lamp_lo, lamp_hi, drive_up, drive_dn}
    localparam logic [3:0] AT_LOW  = 4'b1000;
    localparam logic [3:0] AT_HIGH = 4'b0100;
    localparam logic [3:0] RISING  = 4'b0010;
    localparam logic [3:0] FALLING = 4'b0001;

    always #2.5 clk = ~clk;

    lift2_ctrl uut (
        .clk(clk), .rst(rst), .req_up(req_up), .req_dn(req_dn),
        .top_sense(top_sense), .bot_sense(bot_sense),
        .lamp_lo(lamp_lo), .lamp_hi(lamp_hi),
        .drive_up(drive_up), .drive_dn(drive_dn)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 5000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Wait for an edge, then move 1 ns past it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_in(logic u, logic d, logic t, logic b);
        req_up = u; req_dn = d; top_sense = t; bot_sense = b;
    endtask

    task automatic check_out(string req, logic [3:0] exp);
        logic [3:0] act;
        act = {lamp_lo, lamp_hi, drive_up, drive_dn};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        set_in(0, 0, 0, 0);
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_out("R1 reset state", AT_LOW);
    endtask

    task automatic t_low_ignores();
        do_reset();
        set_in(0, 1, 0, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            check_out("R3 down press at lower landing", AT_LOW);
        end
        set_in(0, 0, 1, 1);
        tick();
        check_out("R3 sensors at lower landing", AT_LOW);
    endtask

    task automatic t_trip_up();
        do_reset();
        set_in(1, 0, 0, 0);
        tick();
        set_in(0, 0, 0, 0);
        check_out("R2 up request starts rise", RISING);
        for (int i = 0; i < 4; i++) begin
            tick();
            check_out("R4 rising held without sensor", RISING);
        end
        set_in(0, 1, 0, 0);
        tick();
        check_out("R5 down press while rising", RISING);
        set_in(1, 1, 0, 1);
        tick();
        check_out("R5 buttons and lower sensor while rising", RISING);
        n_checks++;
        if ($countones({lamp_lo, lamp_hi, drive_up, drive_dn}) != 1) begin
            n_fail++;
            $display("FAIL R11: active outputs actual %0d expected 1",
                     $countones({lamp_lo, lamp_hi, drive_up, drive_dn}));
        end
        set_in(0, 0, 1, 0);
        tick();
        set_in(0, 0, 0, 0);
        check_out("R4 arrival at upper landing", AT_HIGH);
    endtask

    task automatic t_high_and_down();
        set_in(1, 0, 1, 1);
        tick();
        check_out("R7 up press at upper landing", AT_HIGH);
        tick();
        check_out("R7 idle at upper landing", AT_HIGH);
        set_in(0, 1, 0, 0);
        tick();
        set_in(0, 0, 0, 0);
        check_out("R6 down request starts fall", FALLING);
        tick();
        check_out("R8 falling held without sensor", FALLING);
        set_in(1, 1, 1, 0);
        tick();
        check_out("R9 buttons and upper sensor while falling", FALLING);
        set_in(0, 0, 0, 1);
        tick();
        set_in(0, 0, 0, 0);
        check_out("R8 return to lower landing", AT_LOW);
    endtask

    task automatic t_moore();
        do_reset();
        tick();
        set_in(1, 1, 1, 1);
        #1;
        check_out("R10 outputs steady mid-cycle at lower landing", AT_LOW);
        tick();
        set_in(0, 0, 0, 0);
        check_out("R12 both buttons accepted as up", RISING);
        set_in(0, 0, 1, 0);
        #1;
        check_out("R10 sensor mid-cycle does not move outputs", RISING);
        tick();
        set_in(0, 0, 0, 0);
        check_out("R4 arrival after mid-cycle sensor", AT_HIGH);
    endtask

    initial begin
        t_reset();
        t_low_ignores();
        t_trip_up();
        t_high_and_down();
        t_moore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule